// File: doc/BRIEF.md
# Key-Protected Watchdog Interval Timer

This block is an 8-bit up-counter driven from a programmable prescaler. It runs in one of two modes. In interval mode, a counter wrap sets a sticky flag and raises an interrupt request. In watchdog mode, a wrap records a reset event and can request a system reset. Software has to refresh the counter before the wrap, or the reset request fires.

Every write is guarded by a key byte in the upper half of a 16-bit bus word. One write address reaches two different registers, and the key selects which one. Address 0 with key 0xA5 writes the control register. Address 0 with key 0x5A loads the counter. Address 2 holds the reset-control register, which has its own key rules. Reads are 8 bits wide and combinational:
- address 0 returns the control register;
- address 1 returns the counter;
- address 2 returns the reset-control register;
- address 3 returns 0x00.

The interrupt request carries a priority and a vector taken from fields of two external register values supplied on input ports. The interrupt controller and the reset circuitry sit outside this block.

Control register layout:
- bit 7: interval overflow flag;
- bit 6: mode (0 = interval, 1 = watchdog);
- bit 5: count enable;
- bits 4:3: always read 1;
- bits 2:0: clock select.

Reset-control register layout:
- bit 7: watchdog overflow flag;
- bit 6: reset enable;
- bit 5: reset select;
- bits 4:0: always read 1.

Top module: `keyguard_timer`

## Requirements
- R1: After reset the control register reads 0x18, the counter reads 0x00 and the reset-control register reads 0x1F. irqReq and rstReq are 0.
- R2: Writes to address 0 are decoded by the key in the upper byte. Key 0xA5 writes the low byte into the control register, with bits 4:3 forced to 1. Key 0x5A loads the low byte into the counter. Any other upper byte leaves both registers unchanged. Writes to address 3 are ignored.
- R3: Control bits 2:0 select the prescaler divide ratio: 0→2, 1→64, 2→128, 3→256, 4→512, 5→1024, 6→4096, 7→8192. With the counter at 0xFF and the prescaler at zero, the overflow flag appears exactly one divide period after the enabling control write.
- R4: While control bit 5 is 0, the counter does not change, except through a key 0x5A load.
- R5: While control bit 7 or reset-control bit 7 is set, the counter does not advance.
- R6: Disabling and re-enabling counting keeps the prescaler residue. The next increment comes after the remaining clocks of the interrupted period.
- R7: In interval mode (bit 6 = 0), a wrap from 0xFF to 0x00 sets control bit 7. irqReq is 1 exactly while bits 7 and 5 are both 1. irqPrio equals prioSrc[7:4] and irqVec equals vecSrc[14:8].
- R8: A key 0xA5 control write with data bit 7 at 0 clears the interval flag. A write with data bit 7 at 1 leaves the flag as it was.
- R9: At address 2, the exact word 0xA500 clears bit 7. Key 0x5A copies data bits 6:5 into bits 6:5, keeps bit 7 and forces bits 4:0 to 1. Any other word is ignored.
- R10: In watchdog mode (bit 6 = 1), a wrap sets reset-control bit 7 and leaves control bit 7 clear. If bit 6 of reset-control is 1, rstReq rises in the cycle after the wrap edge and stays high for exactly 16 cycles. If bit 6 is 0, rstReq stays low. rstSel always follows reset-control bit 5.
- R11: A counter load clears the prescaler residue, so the first increment after a load comes one full divide period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWrData | input | 16 | Write word: key byte in 15:8, data in 7:0 |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRdData | output | 8 | Read data for busAddr |
| prioSrc | input | 16 | External priority register value (bits 7:4 used) |
| vecSrc | input | 16 | External vector register value (bits 14:8 used) |
| irqReq | output | 1 | Interval-mode interrupt request |
| irqPrio | output | 4 | Interrupt priority |
| irqVec | output | 7 | Interrupt vector |
| rstReq | output | 1 | Watchdog reset request pulse |
| rstSel | output | 1 | Reset select bit |

## Verification
The bench measures the wrap time for several clock-select codes. A wrong entry in the non-uniform divide table shows up as a wrap at the wrong cycle. It interrupts a prescale period by disabling and re-enabling counting, and separately reloads the counter in mid-period. A design that drops the residue, or keeps it across a load, then increments one period early or late. It also sends wrong-key and near-miss words such as 0xA501 and 0x3C40 to both addresses; a decoder that checks too few bits would change a register. Finally it counts the reset pulse cycle by cycle, checks the freeze while a flag is set, and checks that the interrupt is masked when the enable bit is clear.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;
  localparam int CNT_W = 8;
  localparam int CKS_W = 3;
  localparam int MAX_SHIFT = 13;
  localparam int PRESC_W = MAX_SHIFT;

  localparam int ADDR_CTL = 0;
  localparam int ADDR_CNT = 1;
  localparam int ADDR_RST = 2;

  localparam logic [7:0] KEY_CTL = 8'hA5;
  localparam logic [7:0] KEY_CNT = 8'h5A;
  localparam logic [15:0] RST_CLEAR_WORD = 16'hA500;

  typedef struct packed {
    logic             cntLoad;
    logic [CNT_W-1:0] loadVal;
    logic             runEn;
    logic [CKS_W-1:0] divSel;
  } dpStrobes_t;

  function automatic int divShift(input logic [CKS_W-1:0] sel);
    case (sel)
      3'd0: divShift = 1;
      3'd1: divShift = 6;
      3'd2: divShift = 7;
      3'd3: divShift = 8;
      3'd4: divShift = 9;
      3'd5: divShift = 10;
      3'd6: divShift = 12;
      default: divShift = MAX_SHIFT;
    endcase
  endfunction

  function automatic logic [PRESC_W-1:0] divTerminal(input logic [CKS_W-1:0] sel);
    logic [31:0] full;
    full = (32'd1 << divShift(sel)) - 32'd1;
    divTerminal = full[PRESC_W-1:0];
  endfunction
endpackage

// File: rtl/keyguard_ctrl.sv
module keyguard_ctrl
  import keyguard_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWrData,
  input  logic              busWr,
  input  logic              ovfEvent,
  input  logic [CNT_W-1:0]  countQ,
  output dpStrobes_t        strb,
  output logic [7:0]        ctrlQ,
  output logic [7:0]        rstCtlQ,
  output logic [7:0]        busRdData,
  output logic              pulseTrig,
  output logic              irqReq,
  output logic              rstSel
);
  logic             ctlOvf, ctlMode, ctlEn;
  logic [CKS_W-1:0] ctlCks;
  logic             rsOvf, rsEn, rsSel;

  logic atCtl, atRst;
  logic ctrlKeyWr, cntKeyWr, rstClrWr, rstCfgWr;
  logic ivlWrap, wdWrap;

  assign atCtl     = busWr && (busAddr == ADDR_W'(ADDR_CTL));
  assign atRst     = busWr && (busAddr == ADDR_W'(ADDR_RST));
  assign ctrlKeyWr = atCtl && (busWrData[15:8] == KEY_CTL);
  assign cntKeyWr  = atCtl && (busWrData[15:8] == KEY_CNT);
  assign rstClrWr  = atRst && (busWrData == RST_CLEAR_WORD);
  assign rstCfgWr  = atRst && (busWrData[15:8] == KEY_CNT);

  assign ivlWrap = ovfEvent && !ctlMode;
  assign wdWrap  = ovfEvent && ctlMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlOvf  <= 1'b0;
      ctlMode <= 1'b0;
      ctlEn   <= 1'b0;
      ctlCks  <= '0;
    end else begin
      if (ctrlKeyWr) begin
        ctlOvf  <= ctlOvf & busWrData[7];
        ctlMode <= busWrData[6];
        ctlEn   <= busWrData[5];
        ctlCks  <= busWrData[CKS_W-1:0];
      end
      if (ivlWrap) ctlOvf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rsOvf <= 1'b0;
      rsEn  <= 1'b0;
      rsSel <= 1'b0;
    end else begin
      if (rstClrWr) rsOvf <= 1'b0;
      if (rstCfgWr) begin
        rsEn  <= busWrData[6];
        rsSel <= busWrData[5];
      end
      if (wdWrap) rsOvf <= 1'b1;
    end
  end

  assign ctrlQ   = {ctlOvf, ctlMode, ctlEn, 2'b11, ctlCks};
  assign rstCtlQ = {rsOvf, rsEn, rsSel, 5'h1F};

  always_comb begin
    strb.cntLoad = cntKeyWr;
    strb.loadVal = busWrData[CNT_W-1:0];
    strb.runEn   = ctlEn && !ctlOvf && !rsOvf;
    strb.divSel  = ctlCks;
  end

  always_comb begin
    if (busAddr == ADDR_W'(ADDR_CTL))      busRdData = ctrlQ;
    else if (busAddr == ADDR_W'(ADDR_CNT)) busRdData = countQ;
    else if (busAddr == ADDR_W'(ADDR_RST)) busRdData = rstCtlQ;
    else                                   busRdData = 8'h00;
  end

  assign pulseTrig = wdWrap && rsEn;
  assign irqReq    = ctlOvf && ctlEn;
  assign rstSel    = rsSel;
endmodule

// File: rtl/keyguard_datapath.sv
module keyguard_datapath
  import keyguard_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strb,
  output logic [CNT_W-1:0] countQ,
  output logic             ovfEvent
);
  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] termVal;
  logic               tick;

  assign termVal  = divTerminal(strb.divSel);
  assign tick     = strb.runEn && (presc >= termVal);
  assign ovfEvent = tick && (countQ == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc  <= '0;
      countQ <= '0;
    end else if (strb.cntLoad) begin
      presc  <= '0;
      countQ <= strb.loadVal;
    end else if (strb.runEn) begin
      if (tick) begin
        presc  <= '0;
        countQ <= countQ + 1'b1;
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/keyguard_pulse.sv
module keyguard_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic trig,
  output logic pulse
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rstN)                remain <= '0;
    else if (trig)            remain <= PW'(PULSE_LEN);
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign pulse = (remain != '0);
endmodule

// File: rtl/keyguard_timer.sv
module keyguard_timer
  import keyguard_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWrData,
  input  logic              busWr,
  output logic [7:0]        busRdData,
  input  logic [15:0]       prioSrc,
  input  logic [15:0]       vecSrc,
  output logic              irqReq,
  output logic [3:0]        irqPrio,
  output logic [6:0]        irqVec,
  output logic              rstReq,
  output logic              rstSel
);
  dpStrobes_t       strb;
  logic [CNT_W-1:0] countQ;
  logic             ovfEvent;
  logic [7:0]       ctrlQ;
  logic [7:0]       rstCtlQ;
  logic             pulseTrig;
  logic             unusedSrcBits;

  keyguard_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .ovfEvent(ovfEvent), .countQ(countQ), .strb(strb),
    .ctrlQ(ctrlQ), .rstCtlQ(rstCtlQ), .busRdData(busRdData),
    .pulseTrig(pulseTrig), .irqReq(irqReq), .rstSel(rstSel)
  );

  keyguard_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .countQ(countQ), .ovfEvent(ovfEvent)
  );

  keyguard_pulse #(.PULSE_LEN(PULSE_LEN)) pulse_i (
    .clk(clk), .rstN(rstN), .trig(pulseTrig), .pulse(rstReq)
  );

  assign irqPrio = prioSrc[7:4];
  assign irqVec  = vecSrc[14:8];
  assign unusedSrcBits = ^{prioSrc[15:8], prioSrc[3:0], vecSrc[15], vecSrc[7:0]};
endmodule

// File: rtl/keyguard_checker.sv
module keyguard_checker #(
  parameter int ADDR_W    = 2,
  parameter int PULSE_LEN = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [15:0]       busWrData,
  input logic [7:0]        ctrlQ,
  input logic [7:0]        rstCtlQ,
  input logic [7:0]        countQ,
  input logic              rstReq
);
  localparam int HW = $clog2(PULSE_LEN + 2);
  logic [HW-1:0] highRun;
  logic ctlAddr, loadWr, badKeyWr;

  assign ctlAddr  = busWr && (busAddr == '0);
  assign loadWr   = ctlAddr && (busWrData[15:8] == 8'h5A);
  assign badKeyWr = ctlAddr && (busWrData[15:8] != 8'h5A) && (busWrData[15:8] != 8'hA5);

  always_ff @(posedge clk) begin
    if (!rstN)       highRun <= '0;
    else if (rstReq) highRun <= highRun + 1'b1;
    else             highRun <= '0;
  end

  a_r2_bad_key_ignored: assert property (@(posedge clk) disable iff (!rstN)
    badKeyWr |=> $stable(ctrlQ[6:0]));

  a_r4_hold_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[5] && !loadWr) |=> $stable(countQ));

  a_r5_freeze_on_flag: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlQ[7] || rstCtlQ[7]) && !loadWr) |=> $stable(countQ));

  a_r7_flag_after_ff: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlQ[7]) |-> ($past(countQ) == 8'hFF));

  a_r10_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstReq) |-> (highRun == HW'(PULSE_LEN)));

  a_r10_pulse_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> rstCtlQ[7]);
endmodule

bind keyguard_timer keyguard_checker #(.ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN)) chk_i (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData),
  .ctrlQ(ctrlQ), .rstCtlQ(rstCtlQ), .countQ(countQ), .rstReq(rstReq)
);

// File: tb/keyguard_timer_tb_top.sv
module keyguard_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  typedef struct packed {
    logic [1:0]  wAddr;
    logic [15:0] wData;
    logic [1:0]  rAddr;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 16'hA507, 2'd0, 8'h1F, 4'd2},  // R2 control key, bits 4:3 forced
    '{2'd0, 16'h3C40, 2'd0, 8'h1F, 4'd2},  // R2 bad key ignored
    '{2'd0, 16'h5A9C, 2'd1, 8'h9C, 4'd2},  // R2 counter key loads
    '{2'd0, 16'hA55A, 2'd0, 8'h5A, 4'd2},  // R2 control rewrite
    '{2'd0, 16'h00FF, 2'd1, 8'h9C, 4'd4},  // R4 disabled counter holds
    '{2'd2, 16'h5A60, 2'd2, 8'h7F, 4'd9},  // R9 enable and select set
    '{2'd2, 16'h5A9F, 2'd2, 8'h1F, 4'd9},  // R9 bits 6:5 from data
    '{2'd2, 16'h5A40, 2'd2, 8'h5F, 4'd9},  // R9 enable only
    '{2'd2, 16'h3360, 2'd2, 8'h5F, 4'd9},  // R9 bad key ignored
    '{2'd0, 16'hA500, 2'd0, 8'h18, 4'd2},  // R2 control cleared
    '{2'd3, 16'hA5FF, 2'd0, 8'h18, 4'd2}   // R2 unused address ignored
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic        busWr = 1'b0;
  logic [7:0]  busRdData;
  logic [15:0] prioSrc = 16'h12A4;
  logic [15:0] vecSrc = 16'hB755;
  logic        irqReq;
  logic [3:0]  irqPrio;
  logic [6:0]  irqVec;
  logic        rstReq;
  logic        rstSel;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  keyguard_timer dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData), .busWr(busWr),
    .busRdData(busRdData), .prioSrc(prioSrc), .vecSrc(vecSrc), .irqReq(irqReq),
    .irqPrio(irqPrio), .irqVec(irqVec), .rstReq(rstReq), .rstSel(rstSel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  task automatic measureDiv(input logic [2:0] cks, input int div);
    logic [7:0] v;
    int n;
    wr(2'd0, 16'hA500);
    wr(2'd0, 16'h5AFF);
    wr(2'd0, {8'hA5, 8'h20 | {5'd0, cks}});
    n = 0;
    do begin
      waitEdges(1);
      n++;
      rd(2'd0, v);
    end while (!v[7] && n < 9000);
    chk($sformatf("R3 divide for select %0d", cks), n, div);
  endtask

  initial begin
    logic [7:0] v;
    int n;
    waitEdges(3);
    rstN = 1'b1;
    // R1 reset state
    rd(2'd0, v); chk("R1 control reset", v, 8'h18);
    rd(2'd1, v); chk("R1 counter reset", v, 8'h00);
    rd(2'd2, v); chk("R1 reset-control reset", v, 8'h1F);
    chk("R1 irq reset", irqReq, 0);
    chk("R1 rstReq reset", rstReq, 0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i].wAddr, VEC[i].wData);
      rd(VEC[i].rAddr, v);
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].exp);
    end
    wr(2'd2, 16'h5A00);

    // R4 longer hold while disabled
    wr(2'd0, 16'h5A42);
    waitEdges(300);
    rd(2'd1, v); chk("R4 hold after 300 clocks", v, 8'h42);

    // R3 divide ratios
    measureDiv(3'd0, 2);
    measureDiv(3'd1, 64);
    measureDiv(3'd3, 256);
    measureDiv(3'd6, 4096);
    measureDiv(3'd7, 8192);

    // R7 interrupt after interval overflow
    chk("R7 irq after wrap", irqReq, 1);
    chk("R7 priority field", irqPrio, 4'hA);
    chk("R7 vector field", irqVec, 7'h37);
    wr(2'd0, 16'hA580);
    rd(2'd0, v); chk("R8 flag kept by write of 1", v, 8'h98);
    chk("R7 irq masked when disabled", irqReq, 0);
    wr(2'd0, 16'hA5A0);
    chk("R7 irq with enable", irqReq, 1);
    waitEdges(50);
    rd(2'd1, v); chk("R5 freeze on interval flag", v, 8'h00);
    wr(2'd0, 16'hA520);
    rd(2'd0, v); chk("R8 flag cleared", v, 8'h38);
    chk("R8 irq dropped", irqReq, 0);

    // R6 residue kept across disable
    wr(2'd0, 16'hA501);
    wr(2'd0, 16'h5A00);
    wr(2'd0, 16'hA521);
    waitEdges(39);
    wr(2'd0, 16'hA501);
    waitEdges(100);
    rd(2'd1, v); chk("R6 no count while disabled", v, 8'h00);
    wr(2'd0, 16'hA521);
    waitEdges(23);
    rd(2'd1, v); chk("R6 one clock before tick", v, 8'h00);
    waitEdges(1);
    rd(2'd1, v); chk("R6 tick on residue", v, 8'h01);

    // R11 counter load clears residue
    waitEdges(30);
    wr(2'd0, 16'h5A10);
    waitEdges(63);
    rd(2'd1, v); chk("R11 no early tick", v, 8'h10);
    waitEdges(1);
    rd(2'd1, v); chk("R11 tick one period after load", v, 8'h11);

    // R10 watchdog with reset enabled
    wr(2'd0, 16'hA500);
    wr(2'd2, 16'h5A60);
    chk("R10 rstSel follows bit 5", rstSel, 1);
    wr(2'd0, 16'h5AFE);
    wr(2'd0, 16'hA560);
    n = 0;
    do begin
      waitEdges(1);
      n++;
    end while (!rstReq && n < 100);
    chk("R10 pulse start", n, 4);
    n = 1;
    do begin
      waitEdges(1);
      if (rstReq) n++;
    end while (rstReq && n < 100);
    chk("R10 pulse width", n, 16);
    rd(2'd2, v); chk("R10 watchdog flag", v, 8'hFF);
    rd(2'd0, v); chk("R10 interval flag untouched", v, 8'h78);
    chk("R10 no irq in watchdog mode", irqReq, 0);
    rd(2'd1, v); chk("R5 freeze on watchdog flag", v, 8'h00);
    wr(2'd2, 16'hA500);
    rd(2'd2, v); chk("R9 exact clear word", v, 8'h7F);

    // R10 watchdog with reset disabled
    wr(2'd2, 16'h5A00);
    chk("R10 rstSel low", rstSel, 0);
    wr(2'd0, 16'h5AFE);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      waitEdges(1);
      if (rstReq) n++;
    end
    chk("R10 no pulse when disabled", n, 0);
    rd(2'd2, v); chk("R10 flag without pulse", v, 8'h9F);
    wr(2'd2, 16'hA501);
    rd(2'd2, v); chk("R9 near-miss clear ignored", v, 8'h9F);
    wr(2'd2, 16'hA500);
    rd(2'd2, v); chk("R9 clear", v, 8'h1F);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule